// File: doc/BRIEF.md
# Serial Configuration Register Slave

A two-wire serial slave that holds six 8-bit configuration registers for a clock generator's control logic. The block watches SCL and SDA, oversampled by a faster system clock. It recognises START and STOP as SDA edges while SCL is high. It pulls SDA low through an open-drain enable when it acknowledges a byte or sends a zero bit.

A write is addressed to 0xD2. The first two bytes after the address play the role of a command code and a byte count. Both are acknowledged and their values thrown away. The bytes after them land in register 0, then 1, and so on. A read is addressed to 0xD3. It returns a count byte of 6, then registers 0 through 5, and then 0xFF for as long as the master keeps acknowledging. The master may end any write with STOP after a whole byte. A byte is committed only once all eight of its bits are in. Every transfer starts again at register 0.

The register contents leave the block flat on one bus. Three control bits of register 0 are also brought out decoded: bit 3 picks between the latched pin straps and the register frequency bits, bit 1 enables spread spectrum, and bit 0 tristates all outputs.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, register 0 reads 0x00 and registers 1 to 5 read 0xFF; register k sits at regs_o[8k+7:8k].
- R2: The address byte 0xD2 is acknowledged (SDA low in the ninth clock). Any other address byte, such as 0xA0, is not acknowledged, and the data bytes that follow it change no register.
- R3: In a write, the two bytes after the address are acknowledged and discarded, and the data bytes that follow are stored in registers 0, 1, 2 and onward, in that order.
- R4: A STOP after the n-th whole data byte leaves registers n to 5 unchanged, and a STOP in the middle of a byte leaves that byte's register unchanged.
- R5: Data bytes beyond the sixth are acknowledged and change no register.
- R6: A read addressed 0xD3 returns 0x06, then registers 0 to 5, then 0xFF, each byte MSB first. A read changes no register.
- R7: A master NACK ends a read. The slave releases SDA, and the next transaction works normally.
- R8: freq_from_regs equals register 0 bit 3, spread_en equals bit 1, and all_tristate equals bit 0.
- R9: sda_oe changes only while SCL is low and is 0 whenever the slave is idle.
- R10: A repeated START begins a new transfer that writes from register 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | 48 | Register contents, register k at bits 8k+7:8k |
| freq_from_regs | output | 1 | 1: frequency taken from register bits, 0: from latched straps |
| spread_en | output | 1 | Spread spectrum enable |
| all_tristate | output | 1 | Tristate all clock outputs |

## Verification
Each bus input passes two synchronizer flops and one history flop. So an SCL edge acts on the slave's state in the third system clock after it appears, and the registers and sda_oe settle within that time. The bench holds every SCL phase for eight system clocks. It samples SDA for acknowledges and read bits in the middle of the SCL high phase, and it reads regs_o and sda_oe only after the STOP phase has run its full eight clocks. An independent monitor counts sda_oe changes seen at falling clock edges while SCL is high.

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int                 NREGS    = 6,
  parameter logic [6:0]         DEV_ADDR = 7'h69,
  parameter logic [NREGS*8-1:0] DEFAULTS = {{(NREGS-1){8'hFF}}, 8'h00}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREGS*8-1:0] regs_o,
  output logic               freq_from_regs,
  output logic               spread_en,
  output logic               all_tristate
);
  localparam int         IW       = $clog2(NREGS + 4);
  localparam logic [7:0] CNT_BYTE = 8'(NREGS);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;

  logic [2:0]         scl_sh, sda_sh;
  st_t                st;
  logic [3:0]         bitcnt;
  logic [7:0]         sh, tx_byte;
  logic [IW-1:0]      idx;
  logic               addr_ph, is_read, ack_go, sda_oe_q;
  logic [NREGS*8-1:0] regs_q;
  logic               rd_busy, idle_st;

  wire scl_s = scl_sh[1], scl_q = scl_sh[2];
  wire sda_s = sda_sh[1], sda_q = sda_sh[2];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0]    rx_byte = {sh[6:0], sda_s};
  wire [IW-1:0] idx_inc = (&idx) ? idx : idx + 1'b1;

  always_comb begin
    tx_byte = 8'hFF;
    if (idx == '0) tx_byte = CNT_BYTE;
    for (int k = 0; k < NREGS; k++)
      if (idx == IW'(k + 1)) tx_byte = regs_q[k*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      st       <= S_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      idx      <= '0;
      addr_ph  <= 1'b0;
      is_read  <= 1'b0;
      ack_go   <= 1'b0;
      sda_oe_q <= 1'b0;
      regs_q   <= DEFAULTS;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
      if (start_c) begin
        st       <= S_RX;
        addr_ph  <= 1'b1;
        bitcnt   <= '0;
        idx      <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_c) begin
        st       <= S_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= rx_byte;
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd7) begin
                if (addr_ph) begin
                  ack_go  <= (rx_byte[7:1] == DEV_ADDR);
                  is_read <= rx_byte[0];
                end else begin
                  ack_go <= 1'b1;
                  idx    <= idx_inc;
                  for (int k = 0; k < NREGS; k++)
                    if (idx == IW'(k + 2)) regs_q[k*8 +: 8] <= rx_byte;
                end
              end
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (ack_go) begin
                st       <= S_RACK;
                sda_oe_q <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_RACK: if (scl_fall) begin
            addr_ph <= 1'b0;
            bitcnt  <= '0;
            if (is_read) begin
              st       <= S_TX;
              sh       <= tx_byte;
              sda_oe_q <= ~tx_byte[7];
              idx      <= idx_inc;
            end else begin
              st       <= S_RX;
              sda_oe_q <= 1'b0;
            end
          end
          S_TX: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              st       <= S_TACK;
              sda_oe_q <= 1'b0;
            end else begin
              sh       <= {sh[6:0], 1'b0};
              sda_oe_q <= ~sh[6];
              bitcnt   <= bitcnt + 4'd1;
            end
          end
          S_TACK: begin
            if (scl_rise && sda_s) begin
              st <= S_IDLE;
            end else if (scl_fall) begin
              st       <= S_TX;
              bitcnt   <= '0;
              sh       <= tx_byte;
              sda_oe_q <= ~tx_byte[7];
              idx      <= idx_inc;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign rd_busy        = is_read && (st != S_IDLE);
  assign idle_st        = (st == S_IDLE);
  assign sda_oe         = sda_oe_q;
  assign regs_o         = regs_q;
  assign freq_from_regs = regs_q[3];
  assign spread_en      = regs_q[1];
  assign all_tristate   = regs_q[0];
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int                 NREGS    = 6,
  parameter logic [NREGS*8-1:0] DEFAULTS = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic [NREGS*8-1:0] regs_o,
  input logic               rd_busy,
  input logic               idle_st
);
  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    $rose(rst_n) |-> (regs_o == DEFAULTS)); // R1

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    idle_st |-> !sda_oe); // R9

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R9

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |=> $stable(regs_o)); // R6
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.NREGS(NREGS), .DEFAULTS(DEFAULTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .regs_o(regs_o), .rd_busy(rd_busy), .idle_st(idle_st));

// File: tb/tb_cfg_serial_slave.sv
module tb_cfg_serial_slave;
  localparam int Q = 8;
  localparam logic [47:0] DEF = {{5{8'hFF}}, 8'h00};

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe, freq_from_regs, spread_en, all_tristate;
  logic [47:0] regs_o;
  wire sda_i = sda_m & ~sda_oe;
  int checks = 0, errors = 0, scl_hi_changes = 0;
  logic [47:0] model;
  logic prev_oe = 0;

  always #10 clk = ~clk;

  cfg_serial_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i),
    .sda_oe(sda_oe), .regs_o(regs_o), .freq_from_regs(freq_from_regs),
    .spread_en(spread_en), .all_tristate(all_tristate));

  always @(negedge clk) begin
    if (rst_n && scl_m && sda_oe != prev_oe) scl_hi_changes++;
    prev_oe <= sda_oe;
  end

  // {count, d5..d0}: d_k at bits [8k+7:8k]
  localparam logic [55:0] VEC [5] = '{
    {8'd6, 48'h665544332211},
    {8'd2, 48'h0000_0000_5AA5},
    {8'd0, 48'h0},
    {8'd6, 48'h0F1E2D3C4B5A},
    {8'd1, 48'h0000_0000_0008}
  };

  task automatic chk(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n * Q) @(posedge clk); endtask

  task automatic i2c_start;
    sda_m = 1; wq(1); scl_m = 1; wq(1); sda_m = 0; wq(1); scl_m = 0; wq(1);
  endtask

  task automatic i2c_stop;
    sda_m = 0; wq(1); scl_m = 1; wq(1); sda_m = 1; wq(1);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; wq(1); scl_m = 1; wq(2); scl_m = 0; wq(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1; wq(1); scl_m = 1; wq(1);
    @(negedge clk); ack = !sda_i;
    wq(1); scl_m = 0; wq(1);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(1); scl_m = 1; wq(1);
      @(negedge clk); b[i] = sda_i;
      wq(1); scl_m = 0;
    end
    wq(1); sda_m = !give_ack; wq(1); scl_m = 1; wq(2); scl_m = 0; wq(1); sda_m = 1;
  endtask

  task automatic wr_txn(input int n, input logic [63:0] data, input string tag);
    logic ack;
    i2c_start;
    send_byte(8'hD2, ack); chk(ack, {tag, " R2 address D2 ack"}, 48'(ack), 48'd1);
    send_byte(8'h37, ack); chk(ack, {tag, " R3 command ack"}, 48'(ack), 48'd1);
    send_byte(8'h99, ack); chk(ack, {tag, " R3 count ack"}, 48'(ack), 48'd1);
    for (int k = 0; k < n; k++) begin
      send_byte(data[k*8 +: 8], ack);
      chk(ack, {tag, " data ack"}, 48'(ack), 48'd1);
      if (k < 6) model[k*8 +: 8] = data[k*8 +: 8];
    end
    i2c_stop;
  endtask

  task automatic rd_check(input int nbytes, input string tag);
    logic [7:0] b;
    logic [7:0] exp;
    i2c_start;
    begin
      logic ack;
      send_byte(8'hD3, ack); chk(ack, {tag, " R6 address D3 ack"}, 48'(ack), 48'd1);
    end
    for (int k = 0; k < nbytes; k++) begin
      recv_byte(k != nbytes - 1, b);
      exp = (k == 0) ? 8'd6 : (k <= 6) ? model[(k-1)*8 +: 8] : 8'hFF;
      chk(b == exp, {tag, " R6 read byte"}, 48'(b), 48'(exp));
    end
    i2c_stop;
    chk(regs_o == model, {tag, " R6 read leaves registers"}, regs_o, model);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    model = DEF;
    repeat (5) @(posedge clk);
    rst_n = 1;
    wq(1);
    @(negedge clk);
    chk(regs_o == DEF, "R1 reset defaults", regs_o, DEF);
    chk({freq_from_regs, spread_en, all_tristate} == 3'b000, "R8 reset decode",
        48'({freq_from_regs, spread_en, all_tristate}), 48'd0);
    chk(!sda_oe, "R9 idle released", 48'(sda_oe), 48'd0);

    // Vector table: R3 sequential fill, R4 partial stop, R6 readback
    for (int v = 0; v < 5; v++) begin
      wr_txn(int'(VEC[v][55:48]), {16'h0, VEC[v][47:0]}, "R3 R4 vector");
      @(negedge clk);
      chk(regs_o == model, "R3 R4 vector registers", regs_o, model);
      rd_check(8, "vector");
    end

    // R8 decode of register 0
    wr_txn(1, 64'h0B, "R8");
    @(negedge clk);
    chk({freq_from_regs, spread_en, all_tristate} == 3'b111, "R8 decode 0x0B",
        48'({freq_from_regs, spread_en, all_tristate}), 48'd7);
    wr_txn(1, 64'h02, "R8");
    @(negedge clk);
    chk({freq_from_regs, spread_en, all_tristate} == 3'b010, "R8 decode 0x02",
        48'({freq_from_regs, spread_en, all_tristate}), 48'd2);

    // R2 wrong address
    i2c_start;
    send_byte(8'hA0, ack);
    chk(!ack, "R2 wrong address not acked", 48'(ack), 48'd0);
    for (int k = 0; k < 4; k++) send_byte(8'h5C, ack);
    i2c_stop;
    @(negedge clk);
    chk(regs_o == model, "R2 wrong address ignored", regs_o, model);

    // R5 extra bytes
    wr_txn(8, 64'hEEDD_0605_0403_0201, "R5");
    @(negedge clk);
    chk(regs_o == model, "R5 extra bytes discarded", regs_o, model);

    // R4 stop mid-byte in third data byte
    i2c_start;
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'hA1, ack); model[7:0] = 8'hA1;
    send_byte(8'hB2, ack); model[15:8] = 8'hB2;
    send_bits(8'hC3, 4);
    i2c_stop;
    @(negedge clk);
    chk(regs_o == model, "R4 mid-byte stop", regs_o, model);

    // R7 early NACK, then normal traffic
    rd_check(3, "R7");
    @(negedge clk);
    chk(!sda_oe, "R7 sda released after nack", 48'(sda_oe), 48'd0);
    wr_txn(2, 64'h7766, "R7 after nack");
    @(negedge clk);
    chk(regs_o == model, "R7 write after nack", regs_o, model);

    // R10 repeated start restarts at register 0
    i2c_start;
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack);
    model[15:0] = 16'h2211;
    i2c_start;
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'h99, ack);
    model[7:0] = 8'h99;
    i2c_stop;
    @(negedge clk);
    chk(regs_o == model, "R10 repeated start restarts", regs_o, model);
    rd_check(9, "R10 readback");

    chk(scl_hi_changes == 0, "R9 sda_oe stable while SCL high", 48'(scl_hi_changes), 48'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule